// File: doc/BRIEF.md
# Slave-Mode Audio Clock Ratio Checker

This block runs on the master clock of a serial audio port that is in slave mode. The bit clock and the frame clock both come from outside. Each one passes through a two-flop synchronizer into the master-clock domain. Between two consecutive rising edges of the frame clock, the block counts master-clock cycles and bit-clock rising edges. It presents both counts as ratios and decides whether they form a legal pair for the selected speed mode or line mode.

The verdict is conservative. It goes high only after two back-to-back frames have produced the same legal pair, and one frame that differs pulls it low again. A watchdog on the frame clock flags a missing frame clock. While that flag is up, the port enable is held low and the measurement history is discarded, so a port that returns has to qualify again from scratch.

Top module: `clkratio_guard`

## Requirements
- R1: `mclk_ratio_o` shows the number of master-clock cycles between the last two frame-clock rising edges. It changes only as the result of a frame-clock rising edge.
- R2: `bclk_ratio_o` shows the number of bit-clock rising edges counted in that same window.
- R3: With `speed_i`=00 and `line_mode_i`=00, the legal master ratios are 256, 384 and 512, and the legal bit ratios are 32, 48, 64 and 128.
- R4: With `speed_i`=01 and `line_mode_i`=00, the legal master ratios are 128, 192 and 256, and the legal bit ratios are 32, 48 and 64.
- R5: With `speed_i`=10 and `line_mode_i`=00, the legal master ratios are 64, 96 and 128, and the legal bit ratios are 32, 48 and 64.
- R6: With `speed_i`=11 and `line_mode_i`=00, no pair is legal.
- R7: With `line_mode_i`=01, only master 256 with bit 128 is legal, whatever `speed_i` is. With `line_mode_i`=10 or 11, no pair is legal.
- R8: `ratio_ok_o` rises only when a measurement is legal and equal to the measurement just before it. It drops on the first frame that is illegal or differs.
- R9: `frame_lost_o` is high from reset until the first frame-clock edge. It goes high again after 1024 consecutive master-clock cycles with no frame-clock edge, and clears on the next edge.
- R10: While `frame_lost_o` is high, `port_en_o` is low and `ratio_ok_o` is forced low on the following cycle.
- R11: After a loss, the first frame-clock rising edge produces no measurement. Qualifying again takes a fresh pair of equal legal frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; all logic runs on it |
| rst_ni | input | 1 | Synchronous active-low reset |
| bclk_i | input | 1 | Bit clock from outside, asynchronous |
| fclk_i | input | 1 | Frame clock from outside, asynchronous |
| speed_i | input | 2 | Speed mode: 00 single, 01 double, 10 quad, 11 reserved |
| line_mode_i | input | 2 | 00 normal, 01 one-line variant one, 10 variant two, 11 reserved |
| mclk_ratio_o | output | RW | Measured master cycles per frame |
| bclk_ratio_o | output | RW | Measured bit-clock rises per frame |
| ratio_ok_o | output | 1 | Ratios are stable and legal |
| frame_lost_o | output | 1 | Frame clock is absent |
| port_en_o | output | 1 | Port may operate |

## Verification
A single frame-clock rising edge does two things in the same cycle: it closes a measurement, and it is the point at which the bench changes `speed_i` or `line_mode_i`. That measurement is therefore judged against the new rule set. The scoreboard models this directly, so a design that judged against the old mode, or one frame late, shows a wrong `ratio_ok_o` a fixed four cycles after the edge. A second collision is provoked by stopping the frame clock while the verdict is high. The bench checks that the loss flag, the port enable and the verdict all fall together, and that the history is gone when frames resume.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } spd_e;

    typedef enum logic [1:0] {
        LINE_OFF  = 2'b00,
        LINE_V1   = 2'b01,
        LINE_V2   = 2'b10,
        LINE_RSVD = 2'b11
    } line_e;

    // Legality of one measured pair under the selected modes.
    function automatic logic ratio_legal(input logic [1:0]  spd,
                                         input logic [1:0]  line,
                                         input logic [15:0] m,
                                         input logic [15:0] b);
        logic m_ok;
        logic b_ok;
        m_ok = 1'b0;
        b_ok = 1'b0;
        if (line == LINE_V1) begin
            m_ok = (m == 16'd256);
            b_ok = (b == 16'd128);
        end else if (line == LINE_OFF) begin
            case (spd)
                SPD_SINGLE: begin
                    m_ok = (m == 16'd256) || (m == 16'd384) || (m == 16'd512);
                    b_ok = (b == 16'd32) || (b == 16'd48) || (b == 16'd64) || (b == 16'd128);
                end
                SPD_DOUBLE: begin
                    m_ok = (m == 16'd128) || (m == 16'd192) || (m == 16'd256);
                    b_ok = (b == 16'd32) || (b == 16'd48) || (b == 16'd64);
                end
                SPD_QUAD: begin
                    m_ok = (m == 16'd64) || (m == 16'd96) || (m == 16'd128);
                    b_ok = (b == 16'd32) || (b == 16'd48) || (b == 16'd64);
                end
                default: begin
                    m_ok = 1'b0;
                    b_ok = 1'b0;
                end
            endcase
        end
        return m_ok && b_ok;
    endfunction

endpackage

// File: rtl/clkratio_sync.sv
module clkratio_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bclk_i,
    input  logic fclk_i,
    output logic b_rise_o,
    output logic f_rise_o,
    output logic f_edge_o
);
    localparam int NSIG = 2;

    typedef struct packed {
        logic [NSIG-1:0] s1;
        logic [NSIG-1:0] s2;
        logic [NSIG-1:0] s3;
    } sync_t;

    sync_t            q, d;
    logic [NSIG-1:0]  raw;
    logic [NSIG-1:0]  rise;

    assign raw = {fclk_i, bclk_i};

    always_comb begin
        d    = q;
        d.s1 = raw;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    for (genvar i = 0; i < NSIG; i++) begin : g_rise
        assign rise[i] = q.s2[i] & ~q.s3[i];
    end

    assign b_rise_o = rise[0];
    assign f_rise_o = rise[1];
    assign f_edge_o = q.s2[1] ^ q.s3[1];
endmodule

// File: rtl/clkratio_meter.sv
module clkratio_meter #(
    parameter int RW       = 12,
    parameter int LOST_CYC = 1024
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          b_rise_i,
    input  logic          f_rise_i,
    input  logic          f_edge_i,
    output logic [RW-1:0] mrat_o,
    output logic [RW-1:0] brat_o,
    output logic          vld_o,
    output logic          lost_o
);
    localparam int IW = $clog2(LOST_CYC + 1);

    typedef struct packed {
        logic [RW-1:0] mcnt;
        logic [RW-1:0] bcnt;
        logic [RW-1:0] mrat;
        logic [RW-1:0] brat;
        logic          vld;
        logic          primed;
        logic [IW-1:0] idle;
        logic          lost;
    } meter_t;

    meter_t        q, d;
    logic [RW-1:0] bnext;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        bnext = q.bcnt;
        if (b_rise_i && (q.bcnt != '1)) bnext = q.bcnt + RW'(1);
        d.bcnt = bnext;
        if (q.mcnt != '1) d.mcnt = q.mcnt + RW'(1);
        if (f_rise_i) begin
            d.mrat   = q.mcnt;
            d.brat   = bnext;
            d.vld    = q.primed;
            d.primed = 1'b1;
            d.mcnt   = RW'(1);
            d.bcnt   = '0;
        end
        if (f_edge_i) begin
            d.idle = '0;
            d.lost = 1'b0;
        end else begin
            if (q.idle != IW'(LOST_CYC)) d.idle = q.idle + IW'(1);
            if (q.idle >= IW'(LOST_CYC - 1)) d.lost = 1'b1;
        end
        if (d.lost) d.primed = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q      <= '0;
            q.lost <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign mrat_o = q.mrat;
    assign brat_o = q.brat;
    assign vld_o  = q.vld;
    assign lost_o = q.lost;
endmodule

// File: rtl/clkratio_judge.sv
module clkratio_judge
    import clkratio_pkg::*;
#(
    parameter int RW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [1:0]    speed_i,
    input  logic [1:0]    line_mode_i,
    input  logic [RW-1:0] mrat_i,
    input  logic [RW-1:0] brat_i,
    input  logic          vld_i,
    input  logic          lost_i,
    output logic          ok_o
);
    typedef struct packed {
        logic [RW-1:0] prev_m;
        logic [RW-1:0] prev_b;
        logic          have;
        logic          ok;
    } judge_t;

    judge_t q, d;
    logic   legal;
    logic   same;

    assign legal = ratio_legal(speed_i, line_mode_i, 16'(mrat_i), 16'(brat_i));
    assign same  = (mrat_i == q.prev_m) && (brat_i == q.prev_b);

    always_comb begin
        d = q;
        if (lost_i) begin
            d.have = 1'b0;
            d.ok   = 1'b0;
        end else if (vld_i) begin
            d.ok     = q.have && legal && same;
            d.have   = 1'b1;
            d.prev_m = mrat_i;
            d.prev_b = brat_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign ok_o = q.ok;
endmodule

// File: rtl/clkratio_guard.sv
module clkratio_guard #(
    parameter int RW       = 12,
    parameter int LOST_CYC = 1024
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          bclk_i,
    input  logic          fclk_i,
    input  logic [1:0]    speed_i,
    input  logic [1:0]    line_mode_i,
    output logic [RW-1:0] mclk_ratio_o,
    output logic [RW-1:0] bclk_ratio_o,
    output logic          ratio_ok_o,
    output logic          frame_lost_o,
    output logic          port_en_o
);
    logic          b_rise;
    logic          f_rise;
    logic          f_edge;
    logic [RW-1:0] mrat;
    logic [RW-1:0] brat;
    logic          vld;
    logic          lost;

    clkratio_sync u_sync (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .bclk_i   (bclk_i),
        .fclk_i   (fclk_i),
        .b_rise_o (b_rise),
        .f_rise_o (f_rise),
        .f_edge_o (f_edge)
    );

    clkratio_meter #(.RW(RW), .LOST_CYC(LOST_CYC)) u_meter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .b_rise_i (b_rise),
        .f_rise_i (f_rise),
        .f_edge_i (f_edge),
        .mrat_o   (mrat),
        .brat_o   (brat),
        .vld_o    (vld),
        .lost_o   (lost)
    );

    clkratio_judge #(.RW(RW)) u_judge (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .speed_i     (speed_i),
        .line_mode_i (line_mode_i),
        .mrat_i      (mrat),
        .brat_i      (brat),
        .vld_i       (vld),
        .lost_i      (lost),
        .ok_o        (ratio_ok_o)
    );

    assign mclk_ratio_o = mrat;
    assign bclk_ratio_o = brat;
    assign frame_lost_o = lost;
    assign port_en_o    = ~lost;
endmodule

// File: rtl/clkratio_guard_chk.sv
module clkratio_guard_chk #(
    parameter int RW       = 12,
    parameter int LOST_CYC = 1024
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          f_rise,
    input logic          f_edge,
    input logic [1:0]    speed_i,
    input logic [1:0]    line_mode_i,
    input logic [RW-1:0] mclk_ratio_o,
    input logic [RW-1:0] bclk_ratio_o,
    input logic          ratio_ok_o,
    input logic          frame_lost_o
);
    localparam int IW = $clog2(LOST_CYC + 1);

    logic [IW-1:0] quiet_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                       quiet_q <= '0;
        else if (f_edge)                   quiet_q <= '0;
        else if (quiet_q != IW'(LOST_CYC)) quiet_q <= quiet_q + IW'(1);
    end

    AST_RATIO_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(mclk_ratio_o) || !$stable(bclk_ratio_o)) |-> $past(f_rise)); // R1
    AST_OK_ON_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ratio_ok_o) |-> ($stable(mclk_ratio_o) && $stable(bclk_ratio_o))); // R8
    AST_RSVD_SPEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ratio_ok_o) |-> !($past(speed_i) == 2'b11 && $past(line_mode_i) == 2'b00)); // R6
    AST_LINE_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ratio_ok_o) |-> !$past(line_mode_i[1])); // R7
    AST_QUIET_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (quiet_q >= IW'(LOST_CYC)) |-> frame_lost_o); // R9
    AST_LOST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(frame_lost_o) |-> $past(f_edge)); // R9
    AST_LOST_KILLS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_lost_o |=> !ratio_ok_o); // R10
    AST_OK_NOT_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ratio_ok_o) |-> !frame_lost_o); // R10
endmodule

bind clkratio_guard clkratio_guard_chk #(.RW(RW), .LOST_CYC(LOST_CYC)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .f_rise       (f_rise),
    .f_edge       (f_edge),
    .speed_i      (speed_i),
    .line_mode_i  (line_mode_i),
    .mclk_ratio_o (mclk_ratio_o),
    .bclk_ratio_o (bclk_ratio_o),
    .ratio_ok_o   (ratio_ok_o),
    .frame_lost_o (frame_lost_o)
);

// File: tb/clkratio_guard_test.sv
`timescale 1ns/1ps
module clkratio_guard_test;
    localparam int RW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bclk = 1'b0;
    logic          fclk = 1'b0;
    logic [1:0]    speed = 2'b00;
    logic [1:0]    line = 2'b00;
    logic [RW-1:0] mrat;
    logic [RW-1:0] brat;
    logic          ok;
    logic          lost;
    logic          pen;

    always #2 clk = ~clk;

    clkratio_guard #(.RW(RW), .LOST_CYC(1024)) uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .bclk_i       (bclk),
        .fclk_i       (fclk),
        .speed_i      (speed),
        .line_mode_i  (line),
        .mclk_ratio_o (mrat),
        .bclk_ratio_o (brat),
        .ratio_ok_o   (ok),
        .frame_lost_o (lost),
        .port_en_o    (pen)
    );

    typedef struct {
        int    m;
        int    b;
        int    ok;
        string req;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    bit   primed = 0;
    bit   have_prev = 0;
    int   last_m, last_b, prev_m, prev_b;

    task automatic check(input bit cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit legal_ref(input int sp, input int ln, input int m, input int b);
        if (ln == 1) return (m == 256) && (b == 128);
        if (ln != 0) return 0;
        if (sp == 0) return (m inside {256, 384, 512}) && (b inside {32, 48, 64, 128});
        if (sp == 1) return (m inside {128, 192, 256}) && (b inside {32, 48, 64});
        if (sp == 2) return (m inside {64, 96, 128}) && (b inside {32, 48, 64});
        return 0;
    endfunction

    // Driver: generates n frames; each frame start closes the previous measurement.
    task automatic frames(input int sp, input int ln, input int m, input int b,
                          input int n, input string req);
        int p;
        p = m / b;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            speed = 2'(sp);
            line  = 2'(ln);
            fclk  = 1'b1;
            bclk  = 1'b1;
            if (primed) begin
                exp_t it;
                it.m   = last_m;
                it.b   = last_b;
                it.ok  = int'(have_prev && legal_ref(sp, ln, last_m, last_b)
                              && last_m == prev_m && last_b == prev_b);
                it.req = req;
                q.push_back(it);
                have_prev = 1;
                prev_m = last_m;
                prev_b = last_b;
            end
            primed = 1;
            last_m = m;
            last_b = b;
            for (int c = 1; c < m; c++) begin
                @(negedge clk);
                fclk = (c < m / 2);
                bclk = ((c % p) < p / 2);
            end
        end
    endtask

    // Monitor: results settle four cycles after the frame-start drive.
    initial begin
        forever begin
            exp_t it;
            wait (q.size() != 0);
            it = q.pop_front();
            repeat (4) @(negedge clk);
            check(int'(mrat) == it.m, "R1 master ratio", int'(mrat), it.m);
            check(int'(brat) == it.b, "R2 bit ratio", int'(brat), it.b);
            check(int'(ok) == it.ok, {it.req, " verdict"}, int'(ok), it.ok);
        end
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ok == 1'b0, "R8 reset verdict", int'(ok), 0);
        check(lost == 1'b1, "R9 reset lost", int'(lost), 1);
        check(pen == 1'b0, "R10 reset enable", int'(pen), 0);

        frames(0, 0, 256, 64, 3, "R3");
        check(lost == 1'b0 && pen == 1'b1, "R9 frames present", int'(pen), 1);
        frames(0, 0, 384, 48, 3, "R3");
        frames(0, 0, 512, 128, 3, "R3");
        frames(0, 0, 128, 32, 3, "R3");
        frames(1, 0, 192, 48, 3, "R4");
        frames(1, 0, 256, 128, 3, "R4");
        frames(2, 0, 96, 48, 3, "R5");
        frames(2, 0, 64, 32, 3, "R5");
        frames(0, 0, 256, 64, 2, "R8");
        for (int k = 0; k < 2; k++) begin
            frames(0, 0, 384, 64, 1, "R8");
            frames(0, 0, 256, 64, 1, "R8");
        end
        frames(3, 0, 256, 64, 3, "R6");
        frames(0, 1, 256, 128, 3, "R7");
        frames(0, 1, 256, 64, 3, "R7");
        frames(0, 2, 256, 128, 3, "R7");
        frames(2, 0, 64, 32, 3, "R5");
        wait (q.size() == 0);
        repeat (6) @(negedge clk);
        check(ok == 1'b1, "R8 verdict before loss", int'(ok), 1);

        // Stop the frame clock: last edge was the fall 32 cycles before frame end.
        repeat (954) @(negedge clk);
        check(lost == 1'b0, "R9 not yet lost", int'(lost), 0);
        repeat (100) @(negedge clk);
        check(lost == 1'b1, "R9 lost", int'(lost), 1);
        check(pen == 1'b0, "R10 enable gated", int'(pen), 0);
        check(ok == 1'b0, "R10 verdict cleared", int'(ok), 0);
        primed = 0;
        have_prev = 0;

        frames(0, 0, 256, 64, 3, "R11");
        wait (q.size() == 0);
        repeat (6) @(negedge clk);
        check(lost == 1'b0 && pen == 1'b1, "R9 recovered", int'(lost), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule